// File: doc/BRIEF.md
# DRAM Address Multiplexer with Column/Command Indicator

This block drives the external address bus of a memory controller that serves several chip selects, each of which may hold Fast Page, EDO or SDRAM parts. A sequencer presents an access phase together with a flat byte address and the index of the chip select being accessed. On every clock edge where the phase changes, the block registers a new bus value. That value is the row address, the column address, an SDRAM mode word or the plain linear address, depending on the phase and on the configuration of that chip select.

Each chip select has its own column width, from 8 to 11 bits. The row address is taken from the address bits just above the column field. Each chip select also has a bypass bit, which turns the row/column split off for that chip select only, so that parts with their own address decoding see a linear address. A single registered indicator output goes high during the column and SDRAM command phases. External steering logic uses it to tell when the bus carries a column address or a command address. The indicator follows the phase even when bypass is set, so its timing is the same for every chip select.

Top module: `dram_addr_mux`

## Requirements
- R1: While rst_n is low, mem_addr_o is all zeros and mux_ind_o is low.
- R2: Both outputs are registered. They change only on a rising clock edge where the normalized phase differs from the phase taken at the previous change. Otherwise they hold, even when the address, chip select, configuration or mode inputs move. A change to IDLE (code 0) keeps the previous address on the bus.
- R3: Entering ROW (code 1) on a chip select without bypass puts the row address on the bus: byte_addr_i shifted right by ADDR_LSB (default 1) plus the column width, cut to ROW_W (default 13) bits, with all higher bits zero.
- R4: Entering COL (code 2) on a chip select without bypass puts the column address on the bus: byte_addr_i[ADDR_LSB +: column width], with all higher bits zero.
- R5: Entering SDRAM_CMD (code 3, an SDRAM read or write command) on a chip select without bypass puts the same column address as R4 on the bus.
- R6: When the bypass bit of the selected chip select (cfg_bypass_i[cs]) is set, entering ROW, COL or SDRAM_CMD puts byte_addr_i on the bus unchanged. The bypass bits of the other chip selects have no effect.
- R7: Entering LOAD_MODE (code 4) puts mode_val_i on the low MODE_W (default 13) address bits, with all higher bits zero, whatever the bypass setting.
- R8: After a change, mux_ind_o is high when the new phase is COL, SDRAM_CMD or LOAD_MODE, and low when it is IDLE or ROW. The bypass setting does not affect it.
- R9: Phase codes 5 to 7 are treated exactly as IDLE.
- R10: The column width of chip select i is 8 plus the 2-bit code cfg_colw_i[2*i+1:2*i] (code 0 gives 8 bits, code 3 gives 11 bits). This width applies to both the R3 row shift and the R4 column field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | 3 | Access phase from the sequencer |
| cs_sel_i | input | CS_W (2) | Index of the active chip select |
| byte_addr_i | input | ADDR_W (28) | Flat byte address |
| mode_val_i | input | MODE_W (13) | SDRAM mode word |
| cfg_bypass_i | input | NUM_CS (4) | Per chip select bypass bits |
| cfg_colw_i | input | NUM_CS*2 (8) | Per chip select column width codes |
| mem_addr_o | output | ADDR_W (28) | Registered external address bus |
| mux_ind_o | output | 1 | Registered column/command indicator |

## Verification
The bench moves byte_addr_i, the chip select and the mode word while the phase is held. A design that samples on every edge instead of only on a phase change would let the bus drift. It also walks all four column widths across every chip select, which exposes a row field taken from a fixed bit position or a width code read from the wrong chip select. Bypass is set on one chip select while the bits of its neighbours toggle, and LOAD_MODE is entered on bypassed chip selects. A design that routed the linear address into the mode phase, or that gated the indicator with bypass, would produce a wrong bus value or indicator level. Illegal phase codes follow active phases, so a design that decoded them as a real phase would raise the indicator or load a new address.

// File: rtl/dam_pkg.sv
package dam_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ROW  = 3'd1,
      PH_COL  = 3'd2,
      PH_CMD  = 3'd3,
      PH_LMR  = 3'd4
   } phase_e;

   // Map a raw sequencer code onto a legal phase; unused codes act as idle.
   function automatic phase_e norm_phase(input logic [2:0] raw);
      phase_e p;
      case (raw)
         3'd1:    p = PH_ROW;
         3'd2:    p = PH_COL;
         3'd3:    p = PH_CMD;
         3'd4:    p = PH_LMR;
         default: p = PH_IDLE;
      endcase
      return p;
   endfunction

   // Phases during which the column/command indicator is raised.
   function automatic logic ind_for(input phase_e p);
      return (p == PH_COL) || (p == PH_CMD) || (p == PH_LMR);
   endfunction

endpackage

// File: rtl/dam_cfg_sel.sv
module dam_cfg_sel #(
   parameter int NUM_CS = 4,
   parameter int CS_W   = 2,
   parameter int CW_W   = 2
) (
   input  logic [CS_W-1:0]        cs_sel_i,
   input  logic [NUM_CS-1:0]      cfg_bypass_i,
   input  logic [NUM_CS*CW_W-1:0] cfg_colw_i,
   output logic                   bypass_o,
   output logic [CW_W-1:0]        colw_o
);

   if (NUM_CS < 1) begin : g_bad_cs
      $error("dam_cfg_sel: NUM_CS must be at least 1");
   end
   if ((1 << CS_W) < NUM_CS) begin : g_bad_csw
      $error("dam_cfg_sel: CS_W too narrow for NUM_CS");
   end

   logic [NUM_CS-1:0] hit;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_hit
      assign hit[i] = (cs_sel_i == CS_W'(i));
   end

   // An index with no chip select behind it selects nothing: no bypass, narrowest column.
   always_comb begin
      bypass_o = 1'b0;
      colw_o   = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (hit[i]) begin
            bypass_o = cfg_bypass_i[i];
            colw_o   = cfg_colw_i[i*CW_W +: CW_W];
         end
      end
   end

endmodule

// File: rtl/dam_field_extract.sv
module dam_field_extract #(
   parameter int ADDR_W   = 28,
   parameter int ADDR_LSB = 1,
   parameter int COL_MIN  = 8,
   parameter int NUM_W    = 4,
   parameter int ROW_W    = 13,
   parameter int CW_W     = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CW_W-1:0]   colw_i,
   output logic [ADDR_W-1:0] row_o,
   output logic [ADDR_W-1:0] col_o
);

   localparam int COL_MAX = COL_MIN + NUM_W - 1;

   if (ADDR_LSB + COL_MAX + ROW_W > ADDR_W) begin : g_bad_fit
      $error("dam_field_extract: row and column fields exceed ADDR_W");
   end
   if (COL_MIN < 1 || NUM_W < 1) begin : g_bad_col
      $error("dam_field_extract: column width range is empty");
   end

   logic [ADDR_W-1:0] col_v [NUM_W];
   logic [ADDR_W-1:0] row_v [NUM_W];

   // One extractor per legal column width; the row field sits right above it.
   for (genvar k = 0; k < NUM_W; k++) begin : g_width
      localparam int CB = COL_MIN + k;
      assign col_v[k] = ADDR_W'(addr_i[ADDR_LSB +: CB]);
      assign row_v[k] = ADDR_W'(addr_i[ADDR_LSB + CB +: ROW_W]);
   end

   // Codes beyond the range fall back to the widest column.
   always_comb begin
      col_o = col_v[NUM_W-1];
      row_o = row_v[NUM_W-1];
      for (int k = 0; k < NUM_W; k++) begin
         if (int'(colw_i) == k) begin
            col_o = col_v[k];
            row_o = row_v[k];
         end
      end
   end

endmodule

// File: rtl/dam_out_reg.sv
module dam_out_reg
   import dam_pkg::*;
#(
   parameter int ADDR_W = 28,
   parameter int MODE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        phase_i,
   input  logic              bypass_i,
   input  logic [ADDR_W-1:0] row_i,
   input  logic [ADDR_W-1:0] col_i,
   input  logic [ADDR_W-1:0] lin_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              ind_o
);

   if (MODE_W > ADDR_W || MODE_W < 1) begin : g_bad_mode
      $error("dam_out_reg: MODE_W must lie in 1..ADDR_W");
   end

   phase_e            ph_n;
   phase_e            phase_q;
   logic              chg;
   logic [ADDR_W-1:0] addr_n;

   assign ph_n = norm_phase(phase_i);
   assign chg  = (ph_n != phase_q);

   always_comb begin
      addr_n = addr_o;
      case (ph_n)
         PH_ROW:         addr_n = bypass_i ? lin_i : row_i;
         PH_COL, PH_CMD: addr_n = bypass_i ? lin_i : col_i;
         PH_LMR:         addr_n = ADDR_W'(mode_i);
         default:        addr_n = addr_o;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         addr_o  <= '0;
         ind_o   <= 1'b0;
      end else if (chg) begin
         phase_q <= ph_n;
         addr_o  <= addr_n;
         ind_o   <= ind_for(ph_n);
      end
   end

   a_r2_hold_without_change: assert property (@(posedge clk) disable iff (!rst_n)
      !chg |=> ($stable(addr_o) && $stable(ind_o)));

   a_r8_ind_low_on_row: assert property (@(posedge clk) disable iff (!rst_n)
      (chg && ph_n == PH_ROW) |=> !ind_o);

   a_r8_ind_high_on_col_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (chg && (ph_n == PH_COL || ph_n == PH_CMD)) |=> ind_o);

   a_r9_illegal_as_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i > 3'd4 && phase_q != PH_IDLE) |=> (!ind_o && $stable(addr_o)));

   a_r7_mode_on_low_pins: assert property (@(posedge clk) disable iff (!rst_n)
      (chg && ph_n == PH_LMR) |=> (addr_o == ADDR_W'($past(mode_i)) && ind_o));

   a_r6_bypass_linear: assert property (@(posedge clk) disable iff (!rst_n)
      (chg && bypass_i && (ph_n == PH_ROW || ph_n == PH_COL || ph_n == PH_CMD))
      |=> (addr_o == $past(lin_i)));

   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (addr_o == '0 && !ind_o));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
   parameter  int NUM_CS   = 4,
   parameter  int ADDR_W   = 28,
   parameter  int ADDR_LSB = 1,
   parameter  int COL_MIN  = 8,
   parameter  int COL_MAX  = 11,
   parameter  int ROW_W    = 13,
   parameter  int MODE_W   = 13,
   localparam int NUM_W    = COL_MAX - COL_MIN + 1,
   localparam int CW_W     = (NUM_W > 1) ? $clog2(NUM_W) : 1,
   localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2:0]             phase_i,
   input  logic [CS_W-1:0]        cs_sel_i,
   input  logic [ADDR_W-1:0]      byte_addr_i,
   input  logic [MODE_W-1:0]      mode_val_i,
   input  logic [NUM_CS-1:0]      cfg_bypass_i,
   input  logic [NUM_CS*CW_W-1:0] cfg_colw_i,
   output logic [ADDR_W-1:0]      mem_addr_o,
   output logic                   mux_ind_o
);

   if (COL_MAX < COL_MIN) begin : g_bad_range
      $error("dram_addr_mux: COL_MAX below COL_MIN");
   end

   logic              sel_bypass;
   logic [CW_W-1:0]   sel_colw;
   logic [ADDR_W-1:0] row_addr;
   logic [ADDR_W-1:0] col_addr;

   dam_cfg_sel #(
      .NUM_CS (NUM_CS),
      .CS_W   (CS_W),
      .CW_W   (CW_W)
   ) u_cfg (
      .cs_sel_i     (cs_sel_i),
      .cfg_bypass_i (cfg_bypass_i),
      .cfg_colw_i   (cfg_colw_i),
      .bypass_o     (sel_bypass),
      .colw_o       (sel_colw)
   );

   dam_field_extract #(
      .ADDR_W   (ADDR_W),
      .ADDR_LSB (ADDR_LSB),
      .COL_MIN  (COL_MIN),
      .NUM_W    (NUM_W),
      .ROW_W    (ROW_W),
      .CW_W     (CW_W)
   ) u_field (
      .addr_i (byte_addr_i),
      .colw_i (sel_colw),
      .row_o  (row_addr),
      .col_o  (col_addr)
   );

   dam_out_reg #(
      .ADDR_W (ADDR_W),
      .MODE_W (MODE_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase_i  (phase_i),
      .bypass_i (sel_bypass),
      .row_i    (row_addr),
      .col_i    (col_addr),
      .lin_i    (byte_addr_i),
      .mode_i   (mode_val_i),
      .addr_o   (mem_addr_o),
      .ind_o    (mux_ind_o)
   );

   // R10: the row field must start right where the selected column field ends.
   a_r10_row_above_col: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_bypass && int'(sel_colw) < NUM_W && phase_i == 3'd1)
      |-> (row_addr == ADDR_W'(((byte_addr_i >> ADDR_LSB) >> (COL_MIN + int'(sel_colw)))
                               & ((ADDR_W'(1) << ROW_W) - ADDR_W'(1)))));

endmodule

// File: tb/sim_dram_addr_mux.sv
module sim_dram_addr_mux;

   localparam int AW = 28;
   localparam int MW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    phase = 3'd0;
   logic [1:0]    cs = 2'd0;
   logic [AW-1:0] addr = '0;
   logic [MW-1:0] mode = '0;
   logic [3:0]    byp = 4'b0000;
   logic [7:0]    colw = 8'h00;
   logic [AW-1:0] mem_addr;
   logic          ind;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   dram_addr_mux u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .phase_i      (phase),
      .cs_sel_i     (cs),
      .byte_addr_i  (addr),
      .mode_val_i   (mode),
      .cfg_bypass_i (byp),
      .cfg_colw_i   (colw),
      .mem_addr_o   (mem_addr),
      .mux_ind_o    (ind)
   );

   // Behavioural reference model, written from the requirements.
   longint m_addr = 0;
   bit     m_ind = 0;
   int     m_ph = 0;
   string  m_req = "R1";

   always @(posedge clk) begin
      int     p;
      int     cw;
      bit     b;
      longint a;
      if (!rst_n) begin
         m_ph = 0; m_addr = 0; m_ind = 0; m_req = "R1";
      end else begin
         p = int'(phase);
         if (p > 4) p = 0;
         if (p == m_ph) begin
            m_req = (phase > 3'd4) ? "R9 R2" : "R2";
         end else begin
            m_ph = p;
            cw = 8 + int'(colw[2*int'(cs) +: 2]);
            b  = byp[cs];
            a  = longint'(addr);
            case (p)
               1: begin
                  m_addr = b ? a : ((a / 2) / (longint'(1) << cw)) % (longint'(1) << 13);
                  m_req  = b ? "R6" : "R3 R10";
               end
               2, 3: begin
                  m_addr = b ? a : (a / 2) % (longint'(1) << cw);
                  m_req  = b ? "R6" : ((p == 2) ? "R4 R10" : "R5 R10");
               end
               4: begin
                  m_addr = longint'(mode);
                  m_req  = "R7";
               end
               default: m_req = (phase > 3'd4) ? "R9" : "R2";
            endcase
            m_ind = (p >= 2);
         end
      end
   end

   task automatic check_now();
      checks++;
      if (longint'(mem_addr) != m_addr || ind != m_ind) begin
         errors++;
         $display("FAIL %s R8: addr=%h ind=%0b expected addr=%h ind=%0b",
                  m_req, mem_addr, ind, m_addr[AW-1:0], m_ind);
      end
   endtask

   task automatic step(input logic [2:0] ph, input logic [1:0] c, input logic [AW-1:0] a);
      @(negedge clk);
      check_now();
      phase = ph; cs = c; addr = a; mode = MW'($urandom);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state observed with active inputs.
      phase = 3'd2; addr = 28'hABCDEF1; mode = 13'h1A5; byp = 4'b1111;
      repeat (3) begin @(negedge clk); check_now(); end
      phase = 3'd0;
      @(negedge clk); check_now();
      rst_n = 1'b1;
      byp  = 4'b0100;
      colw = {2'd2, 2'd1, 2'd3, 2'd0};  // cs3=10, cs2=9, cs1=11, cs0=8 bits
      // Directed: each chip select through every phase, with hold cycles.
      for (int c = 0; c < 4; c++) begin
         step(3'd1, 2'(c), 28'h5A5F3C7 + AW'(c));
         step(3'd1, 2'(c), 28'h0F0F0F0);          // R2 hold on address change
         step(3'd1, 2'(c ^ 1), 28'h1234567);      // R2 hold on cs change
         step(3'd2, 2'(c), 28'h7FFFFFF);
         step(3'd0, 2'(c), 28'h0000001);          // R2 idle keeps address
         step(3'd3, 2'(c), 28'h3C3C3C3);
         step(3'd6, 2'(c), 28'h2222222);          // R9
         step(3'd4, 2'(c), 28'h1111111);          // R7
         step(3'd7, 2'(c), 28'h4444444);          // R9
         step(3'd5, 2'(c), 28'h5555555);          // R9 stays idle
      end
      // R6: bypass on one cs while neighbours' bits toggle; LOAD_MODE under bypass.
      byp = 4'b1010;
      for (int c = 0; c < 4; c++) begin
         step(3'd1, 2'(c), 28'hFEDCBA9);
         byp = byp ^ 4'(~(1 << c));
         step(3'd2, 2'(c), 28'h0123456);
         step(3'd4, 2'(c), 28'h0);
         step(3'd3, 2'(c), 28'h9ABCDEF);
         step(3'd0, 2'(c), 28'h9ABCDEF);
      end
      // Random phases and configuration.
      for (int n = 0; n < 3000; n++) begin
         byp  = 4'($urandom);
         colw = 8'($urandom);
         step(3'($urandom_range(0, 7)), 2'($urandom), AW'($urandom));
      end
      @(negedge clk); check_now();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule